// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into frames on an asynchronous serial line. A one-deep holding register accepts a character from the host side. An independent shift register sends the frames, so the host can load the next character while the current one is still going out. The bit rate comes from an external one-cycle `baud_tick` enable. Each bit of a frame lasts from one tick to the next.

The line format is set by configuration inputs:

- character length of 7 or 8 bits;
- parity of none, even or odd;
- bit order of least- or most-significant first;
- one or two stop bits;
- a multiprocessor marking scheme: off, idle-line or address-bit.

The configuration is captured into the frame when a character moves from the holding register into the shifter. Changing it during a frame therefore has no effect on that frame. Two outputs report progress: `buf_empty` shows that the holding register can take a character, and `busy` shows that a frame is on the line.

Top module: `async_tx_serializer`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `buf_empty` is 1; the line stays high whenever no frame is being sent.
- R2: A frame is sent in this order: a low start bit, the data bits, the address bit (address-bit mode only), the parity bit (when enabled), then the stop bits, which are high. The start bit begins on the clock edge that loads the shifter, and each later bit begins at the next `baud_tick`.
- R3: With `cfg_len8`=1 all eight bits of `wr_data` are sent. With `cfg_len8`=0 only `wr_data[6:0]` are sent, and `wr_data[7]` is ignored.
- R4: With `cfg_par_en`=1 one parity bit is added, computed over the sent data bits and the address bit when present. `cfg_par_odd`=0 makes the total count of ones even, and `cfg_par_odd`=1 makes it odd. With `cfg_par_en`=0 no parity bit is sent.
- R5: With `cfg_msb_first`=0 data go out lowest bit first. With `cfg_msb_first`=1 the highest sent bit goes first (bit 7 for 8-bit characters, bit 6 for 7-bit characters).
- R6: `cfg_two_stop`=0 sends one stop bit, and `cfg_two_stop`=1 sends two.
- R7: With `cfg_mp_mode`=2'b10 (address-bit mode) the frame carries one extra bit after the data bits, equal to the `wr_addr` value written with the character (1 marks an address, 0 marks data).
- R8: With `cfg_mp_mode`=2'b01 (idle-line mode), a character written with `wr_addr`=1 is preceded by 11 bit times of high line before its start bit. With `wr_addr`=0 no extra bit is sent. Codes 2'b00 and 2'b11 disable marking.
- R9: A character written while the shifter is idle moves to the shifter on the next clock edge. On that edge `buf_empty` returns to 1, `busy` rises and `txd` goes low.
- R10: A character written while a frame is in progress stays in the holding register, with `buf_empty`=0, until the tick that ends the last stop bit. On that tick edge it is loaded, so its start bit follows the stop bit with no idle gap, and `buf_empty` returns to 1.
- R11: A write while `buf_empty` is 0 is ignored and leaves the held character unchanged.
- R12: Configuration changes while a frame is in progress do not alter that frame.
- R13: While `busy` is 1, `txd` changes only on a clock edge where `baud_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len8 | input | 1 | 1: 8-bit characters, 0: 7-bit characters |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_msb_first | input | 1 | 1: most significant data bit first |
| cfg_two_stop | input | 1 | 1: two stop bits, 0: one |
| cfg_mp_mode | input | 2 | 00/11 off, 01 idle-line, 10 address-bit |
| baud_tick | input | 1 | One-cycle bit-rate enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| wr_addr | input | 1 | Marks the character as an address |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register can accept a character |
| busy | output | 1 | A frame is on the line |

## Verification
The bench walks a table of line formats and compares every bit time of each frame with a frame assembled from the rules, so a wrong bit order, a parity computed without the address bit, or a dropped stop bit shows up as a mismatched frame. Back-to-back characters are checked for a start bit right after the last stop bit; a design that waits an extra tick would leave a high gap, and one that loads early would cut the stop bit short. A third write to a full holding register must leave the frames unchanged; a design that overwrites would send the wrong second character. Configuration is changed in the middle of a frame to catch a design that reads live settings instead of captured ones.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

   typedef enum logic [1:0] {
      MP_OFF       = 2'b00,
      MP_IDLE_LINE = 2'b01,
      MP_ADDR_BIT  = 2'b10,
      MP_RSVD      = 2'b11
   } mp_mode_e;

   typedef struct packed {
      logic     len_long;
      logic     par_en;
      logic     par_odd;
      logic     msb_first;
      logic     two_stop;
      mp_mode_e mp;
   } tx_cfg_t;

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_addr,
   input  logic              take,
   output logic              empty,
   output logic [DATA_W-1:0] q_data,
   output logic              q_addr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty  <= 1'b1;
         q_data <= '0;
         q_addr <= 1'b0;
      end else if (take) begin
         empty <= 1'b1;
      end else if (wr_valid && empty) begin
         q_data <= wr_data;
         q_addr <= wr_addr;
         empty  <= 1'b0;
      end
   end

endmodule

// File: rtl/tx_frame_build.sv
module tx_frame_build
   import async_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SHORT_W   = 7,
   parameter int IDLE_GAP  = 11,
   parameter int STOP_LONG = 2,
   parameter int FRAME_W   = 24,
   parameter int LEN_W     = 5
) (
   input  tx_cfg_t            cfg,
   input  logic [DATA_W-1:0]  data,
   input  logic               addr,
   output logic [FRAME_W-1:0] frame,
   output logic [LEN_W-1:0]   flen
);

   logic [DATA_W-1:0] rev_long;
   logic [DATA_W-1:0] rev_short;
   logic [DATA_W-1:0] short_mask;

   // reversed views of the character for both lengths
   for (genvar g = 0; g < DATA_W; g++) begin : g_rev
      assign rev_long[g] = data[DATA_W-1-g];
      if (g < SHORT_W) begin : g_in
         assign rev_short[g]  = data[SHORT_W-1-g];
         assign short_mask[g] = 1'b1;
      end else begin : g_out
         assign rev_short[g]  = 1'b0;
         assign short_mask[g] = 1'b0;
      end
   end

   logic [DATA_W-1:0]  sent;
   logic [DATA_W-1:0]  seq;
   logic               has_abit;
   logic               has_gap;
   logic               par_bit;
   logic [FRAME_W-1:0] core;
   logic [LEN_W-1:0]   pos;

   always_comb begin
      sent     = cfg.len_long ? data : (data & short_mask);
      if (cfg.msb_first) seq = cfg.len_long ? rev_long : rev_short;
      else               seq = sent;
      has_abit = (cfg.mp == MP_ADDR_BIT);
      has_gap  = (cfg.mp == MP_IDLE_LINE) && addr;
      par_bit  = (^sent) ^ (has_abit & addr) ^ cfg.par_odd;

      core    = '1;
      core[0] = 1'b0;
      pos     = LEN_W'(1);
      for (int i = 0; i < DATA_W; i++) begin
         if (cfg.len_long || (i < SHORT_W)) begin
            core[pos] = seq[i];
            pos       = pos + LEN_W'(1);
         end
      end
      if (has_abit) begin
         core[pos] = addr;
         pos       = pos + LEN_W'(1);
      end
      if (cfg.par_en) begin
         core[pos] = par_bit;
         pos       = pos + LEN_W'(1);
      end
      pos = pos + (cfg.two_stop ? LEN_W'(STOP_LONG) : LEN_W'(1));

      if (has_gap) begin
         frame = {core[FRAME_W-1-IDLE_GAP:0], {IDLE_GAP{1'b1}}};
         flen  = pos + LEN_W'(IDLE_GAP);
      end else begin
         frame = core;
         flen  = pos;
      end
   end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
   parameter int FRAME_W = 24,
   parameter int LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [LEN_W-1:0]   flen,
   output logic               line,
   output logic               busy,
   output logic               last_tick
);

   logic [FRAME_W-1:0] shreg;
   logic [LEN_W-1:0]   remain;

   assign busy      = (remain != '0);
   assign last_tick = tick && (remain == LEN_W'(1));
   assign line      = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '1;
         remain <= '0;
      end else if (load) begin
         shreg  <= frame;
         remain <= flen;
      end else if (tick && busy) begin
         shreg  <= {1'b1, shreg[FRAME_W-1:1]};
         remain <= remain - LEN_W'(1);
      end
   end

endmodule

// File: rtl/async_tx_serializer.sv
module async_tx_serializer
   import async_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int SHORT_W   = 7,
   parameter int IDLE_GAP  = 11,
   parameter int STOP_LONG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_len8,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_msb_first,
   input  logic              cfg_two_stop,
   input  logic [1:0]        cfg_mp_mode,
   input  logic              baud_tick,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_addr,
   output logic              txd,
   output logic              buf_empty,
   output logic              busy
);

   localparam int FRAME_W = IDLE_GAP + 1 + DATA_W + 2 + STOP_LONG;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   if (SHORT_W < 1 || SHORT_W >= DATA_W) begin : g_bad_short
      $error("SHORT_W must lie between 1 and DATA_W-1");
   end
   if (STOP_LONG < 2) begin : g_bad_stop
      $error("STOP_LONG must be at least 2");
   end
   if (IDLE_GAP < 1 || IDLE_GAP >= FRAME_W) begin : g_bad_gap
      $error("IDLE_GAP out of range");
   end

   tx_cfg_t            cfg;
   logic [DATA_W-1:0]  hold_data;
   logic               hold_addr;
   logic               take;
   logic               last_tick;
   logic [FRAME_W-1:0] frame;
   logic [LEN_W-1:0]   flen;

   always_comb begin
      cfg.len_long  = cfg_len8;
      cfg.par_en    = cfg_par_en;
      cfg.par_odd   = cfg_par_odd;
      cfg.msb_first = cfg_msb_first;
      cfg.two_stop  = cfg_two_stop;
      cfg.mp        = mp_mode_e'(cfg_mp_mode);
   end

   assign take = !buf_empty && (!busy || last_tick);

   tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wr_valid),
      .wr_data (wr_data),
      .wr_addr (wr_addr),
      .take    (take),
      .empty   (buf_empty),
      .q_data  (hold_data),
      .q_addr  (hold_addr)
   );

   tx_frame_build #(
      .DATA_W   (DATA_W),
      .SHORT_W  (SHORT_W),
      .IDLE_GAP (IDLE_GAP),
      .STOP_LONG(STOP_LONG),
      .FRAME_W  (FRAME_W),
      .LEN_W    (LEN_W)
   ) u_build (
      .cfg  (cfg),
      .data (hold_data),
      .addr (hold_addr),
      .frame(frame),
      .flen (flen)
   );

   tx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .load     (take),
      .frame    (frame),
      .flen     (flen),
      .line     (txd),
      .busy     (busy),
      .last_tick(last_tick)
   );

endmodule

// File: rtl/async_tx_serializer_chk.sv
module async_tx_serializer_chk (
   input logic clk,
   input logic rst_n,
   input logic baud_tick,
   input logic wr_valid,
   input logic txd,
   input logic buf_empty,
   input logic busy
);

   AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd)); // R6

   AST_REFILL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> busy); // R9

   AST_IDLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !buf_empty) |=> (busy && buf_empty)); // R9

   AST_FILL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_empty) |-> $past(wr_valid)); // R11

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !baud_tick) |=> $stable(txd)); // R13

endmodule

bind async_tx_serializer async_tx_serializer_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .baud_tick(baud_tick),
   .wr_valid (wr_valid),
   .txd      (txd),
   .buf_empty(buf_empty),
   .busy     (busy)
);

// File: tb/async_tx_serializer_test.sv
module async_tx_serializer_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cfg_len8, cfg_par_en, cfg_par_odd, cfg_msb_first, cfg_two_stop;
   logic [1:0] cfg_mp_mode;
   logic       baud_tick;
   logic       wr_valid;
   logic [7:0] wr_data;
   logic       wr_addr;
   logic       txd, buf_empty, busy;

   always #2 clk = ~clk;

   async_tx_serializer uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .cfg_msb_first(cfg_msb_first), .cfg_two_stop(cfg_two_stop),
      .cfg_mp_mode(cfg_mp_mode), .baud_tick(baud_tick),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_addr(wr_addr),
      .txd(txd), .buf_empty(buf_empty), .busy(busy)
   );

   // {len[20:16], l8, pe, po, msb, two, mode[10:9], addr, data[7:0]}
   localparam logic [20:0] VEC [0:8] = '{
      {5'd10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'hA5},
      {5'd10, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'hD3},
      {5'd12, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 8'h4E},
      {5'd10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 8'hB1},
      {5'd12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 8'h5A},
      {5'd11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 8'h81},
      {5'd21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 8'h66},
      {5'd11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 8'h2C},
      {5'd12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 8'h00}
   };

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   bit cap [0:63];
   int cap_n = 0;
   bit cap_on = 1'b0;

   bit prev_busy = 1'b0, prev_tick = 1'b0, prev_txd = 1'b1;
   int hold_viol = 0;

   // capture one line value per bit time and watch for mid-bit changes
   always @(negedge clk) begin
      if (cap_on && baud_tick && busy && cap_n < 64) begin
         cap[cap_n] = txd;
         cap_n++;
      end
      if (rst_n && prev_busy && !prev_tick && busy && (txd != prev_txd))
         hold_viol++;
      prev_busy = busy;
      prev_tick = baud_tick;
      prev_txd  = txd;
   end

   initial begin
      baud_tick = 1'b0;
      forever begin
         repeat (3) @(negedge clk);
         baud_tick = 1'b1;
         @(negedge clk);
         baud_tick = 1'b0;
      end
   end

   function automatic string vec_tag(input int k);
      case (k)
         0: return "R2 R3";
         1: return "R3 R4";
         2: return "R4 R5 R6";
         3: return "R3 R5 R6";
         4: return "R4 R7";
         5: return "R7";
         6: return "R8";
         7: return "R8 R5";
         default: return "R4 R7";
      endcase
   endfunction

   function automatic int exp_frame(input bit l8, input bit pe, input bit po,
                                    input bit msb, input bit two,
                                    input bit [1:0] md, input bit ad,
                                    input bit [7:0] d, output bit [63:0] f);
      int n = 0;
      int nb = l8 ? 8 : 7;
      bit ones = 1'b0;
      f = '0;
      if (md == 2'b01 && ad) begin
         for (int k = 0; k < 11; k++) begin
            f[n] = 1'b1;
            n++;
         end
      end
      f[n] = 1'b0;
      n++;
      for (int k = 0; k < nb; k++) begin
         f[n] = msb ? d[nb-1-k] : d[k];
         ones ^= d[k];
         n++;
      end
      if (md == 2'b10) begin
         f[n] = ad;
         ones ^= ad;
         n++;
      end
      if (pe) begin
         f[n] = po ? ~ones : ones;
         n++;
      end
      f[n] = 1'b1;
      n++;
      if (two) begin
         f[n] = 1'b1;
         n++;
      end
      return n;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] cap_vec();
      logic [63:0] v = '0;
      for (int k = 0; k < 64; k++) if (k < cap_n) v[k] = cap[k];
      return v;
   endfunction

   task automatic set_cfg(input bit l8, input bit pe, input bit po, input bit msb,
                          input bit two, input bit [1:0] md);
      cfg_len8 = l8; cfg_par_en = pe; cfg_par_odd = po;
      cfg_msb_first = msb; cfg_two_stop = two; cfg_mp_mode = md;
   endtask

   task automatic write_char(input bit [7:0] d, input bit a);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      wr_addr  = a;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (busy || !buf_empty) @(negedge clk);
   endtask

   initial begin
      bit [63:0] ef, ef2;
      int el, el2;
      rst_n = 1'b0;
      wr_valid = 1'b0; wr_data = '0; wr_addr = 1'b0;
      set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 txd idle", 64'(txd), 64'd1);
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 buf_empty", 64'(buf_empty), 64'd1);

      // table of formats
      for (int k = 0; k < 9; k++) begin
         logic [20:0] v = VEC[k];
         @(negedge clk);
         set_cfg(v[15], v[14], v[13], v[12], v[11], v[10:9]);
         el = exp_frame(v[15], v[14], v[13], v[12], v[11], v[10:9], v[8], v[7:0], ef);
         cap_n = 0;
         cap_on = 1'b1;
         write_char(v[7:0], v[8]);
         drain();
         cap_on = 1'b0;
         chk({vec_tag(k), " length"}, 64'(cap_n), 64'(v[20:16]));
         chk({vec_tag(k), " bits"}, cap_vec(), ef);
         chk("R1 idle after frame", 64'(txd), 64'd1);
      end

      // handoff while idle
      set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00);
      cap_n = 0;
      cap_on = 1'b1;
      write_char(8'h3C, 1'b0);
      chk("R9 held before load", 64'({buf_empty, busy, txd}), 64'b001);
      @(negedge clk);
      chk("R9 loaded", 64'({buf_empty, busy, txd}), 64'b110);
      // second character while busy, third while full
      write_char(8'hC3, 1'b0);
      chk("R10 held during frame", 64'(buf_empty), 64'd0);
      write_char(8'hFF, 1'b1);
      wait (cap_n == 10);
      chk("R10 still held at last stop", 64'(buf_empty), 64'd0);
      @(negedge clk);
      chk("R10 back-to-back start", 64'({buf_empty, busy, txd}), 64'b110);
      drain();
      cap_on = 1'b0;
      el  = exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'h3C, ef);
      el2 = exp_frame(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 8'hC3, ef2);
      chk("R11 two frames only", 64'(cap_n), 64'(el + el2));
      chk("R10 R11 stream", cap_vec(), ef | (ef2 << el));
      repeat (8) @(negedge clk);
      chk("R11 nothing pending", 64'({buf_empty, busy}), 64'b10);

      // configuration change during a frame
      set_cfg(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00);
      el = exp_frame(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 8'h96, ef);
      cap_n = 0;
      cap_on = 1'b1;
      write_char(8'h96, 1'b0);
      repeat (6) @(negedge clk);
      set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10);
      drain();
      cap_on = 1'b0;
      chk("R12 length", 64'(cap_n), 64'(el));
      chk("R12 bits", cap_vec(), ef);

      chk("R13 no mid-bit change", 64'(hold_viol), 64'd0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule